// File: doc/BRIEF.md
# Write Merge Buffer with Store Ordering Control

This block gathers small noncacheable CPU stores into one aligned 8-byte window so they reach the system bus as a single write. It also decides when a store may commit into a cache line held in the modified or exclusive state. A store is offered with its address, byte enables, data and a memory class. The memory class is produced by an address-range lookup outside this block. Stores of the write-combining class merge into the window. Uncached stores go to the bus on their own. Cacheable stores become cache commits.

Commits to cached lines wait on two things. The first is an external input that reports the system write buffer as empty. The second is a selectable ordering level. Higher levels also wait for the merge window itself, because bytes held inside the window are invisible on the bus, so the external input alone cannot order them. The bus side is a simple request/acknowledge port: the request and its payload stay fixed until the acknowledge arrives.

Top module: `wmb_top`

## Requirements
- R1: After reset the bus request is low, no cache commit is signalled, and no store is stalled; stall is only ever raised while a store is offered.
- R2: Write-combining stores (`st_mtype` = 2'b01) whose address lies in the open 8-byte aligned window merge into it. The byte enables are ORed together, and a later store's byte replaces an earlier one in the same lane. A flush issues one bus write whose address has its low 3 bits zero and which carries the ORed enables and the merged lane data.
- R3: A write-combining store outside the open window is stalled. The window is flushed, and once the flush is acknowledged the store is accepted and opens a new window.
- R4: While `bus_req` is high and `bus_ack` is low, the request and its address, enables and data do not change. An acknowledged flush leaves the window empty.
- R5: A cacheable store (`st_mtype` = 2'b10) is stalled and not committed while `ext_empty` is low. It commits in the first cycle `ext_empty` is high, provided the ordering level allows it.
- R6: At level 0 (`ord_level` = 2'b00) a cacheable store commits without stalling even when the window holds bytes, and the window is left untouched.
- R7: At level 1 a cacheable store stalls while the window holds any byte. It forces a flush and commits once the flush is acknowledged.
- R8: At level 2 an uncached store (`st_mtype` = 2'b00 or 2'b11) that arrives while the window holds bytes stalls. The window is flushed first, and the uncached write follows as the next bus write.
- R9: At levels 0 and 1 an uncached store is issued at once as its own bus write, carrying its own address, enables and data. The window contents are preserved and flushed intact later.
- R10: Level encoding 2'b11 behaves exactly like level 2.
- R11: A write-combining store is stalled for as long as any bus write is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store offered this cycle |
| st_mtype | input | 2 | Memory class: 00 uncached, 01 write-combining, 10 cacheable hit on M/E line, 11 uncached |
| st_addr | input | ADDR_W | Store byte address |
| st_be | input | LANES | Store byte enables, one per lane |
| st_data | input | 8*LANES | Store data, lane i in bits 8i+7..8i |
| ord_level | input | 2 | Ordering level 0..2, 3 acts as 2 |
| ext_empty | input | 1 | External write buffer empty |
| st_stall | output | 1 | Offered store is not taken this cycle |
| cache_commit | output | 1 | Offered cacheable store commits to its cache line this cycle |
| bus_req | output | 1 | Bus write request, held until acknowledged |
| bus_addr | output | ADDR_W | Bus write address |
| bus_be | output | LANES | Bus write byte enables |
| bus_data | output | 8*LANES | Bus write data |
| bus_ack | input | 1 | Bus write accepted |

## Verification
A lost or stale byte-enable bit in the window shows up at the next flush as a wrong enable mask or wrong lane data on the bus, so every merge pattern is closed by a forced flush and compared byte by byte. A wrong window tag shows either as a missing flush with zero stall cycles or as a spurious one. A wrong ordering decision shows in the same cycle the store is offered, as a stall count that differs from the exact acknowledge latency plus one, or as a commit that arrives while the window still holds data. The order of writes in the bus log exposes an uncached write that overtakes a window that should have been flushed before it.

// File: rtl/wmb_pkg.sv
package wmb_pkg;

   typedef enum logic [1:0] {
      MT_UNCACHED = 2'b00,
      MT_COMBINE  = 2'b01,
      MT_CACHED   = 2'b10,
      MT_UNC_ALT  = 2'b11
   } mtype_e;

   typedef enum logic [1:0] {
      ORD_PIN_ONLY = 2'b00,
      ORD_WINDOW   = 2'b01,
      ORD_FULL     = 2'b10,
      ORD_RESERVED = 2'b11
   } ord_e;

   // Window gating applies to cache commits at level 1 and above
   function automatic logic ord_gates_commit(input logic [1:0] lvl);
      return lvl != ORD_PIN_ONLY;
   endfunction

   // Window drains before uncached stores at the strictest level (reserved included)
   function automatic logic ord_gates_uncached(input logic [1:0] lvl);
      return (lvl == ORD_FULL) || (lvl == ORD_RESERVED);
   endfunction

endpackage

// File: rtl/wmb_merge_buf.sv
module wmb_merge_buf #(
   parameter int ADDR_W = 32,
   parameter int LANES  = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-$clog2(LANES)-1:0] wr_tag,
   input  logic [LANES-1:0]           wr_be,
   input  logic [LANES*8-1:0]         wr_data,
   input  logic                       clr,
   output logic [ADDR_W-1:0]          win_base,
   output logic [LANES-1:0]           acc_be,
   output logic [LANES*8-1:0]         acc_data,
   output logic                       any_valid,
   output logic                       win_hit
);
   localparam int OFF_W = $clog2(LANES);
   localparam int TAG_W = ADDR_W - OFF_W;

   logic [TAG_W-1:0] tag_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         tag_q <= '0;
      else if (wr_en)
         tag_q <= wr_tag;
   end

   for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
      logic       vld_q;
      logic [7:0] byte_q;

      always_ff @(posedge clk) begin
         if (!rst_n)
            vld_q <= 1'b0;
         else if (clr)
            vld_q <= 1'b0;
         else if (wr_en && wr_be[gi])
            vld_q <= 1'b1;
      end

      always_ff @(posedge clk) begin
         if (!rst_n)
            byte_q <= '0;
         else if (wr_en && wr_be[gi])
            byte_q <= wr_data[gi*8 +: 8];
      end

      assign acc_be[gi]          = vld_q;
      assign acc_data[gi*8 +: 8] = byte_q;
   end

   assign any_valid = |acc_be;
   assign win_hit   = any_valid && (wr_tag == tag_q);
   assign win_base  = {tag_q, {OFF_W{1'b0}}};

endmodule

// File: rtl/wmb_order_ctl.sv
module wmb_order_ctl
   import wmb_pkg::*;
(
   input  logic       st_valid,
   input  logic [1:0] st_mtype,
   input  logic [1:0] ord_level,
   input  logic       ext_empty,
   input  logic       buf_any,
   input  logic       win_hit,
   input  logic       bus_busy,
   output logic       st_stall,
   output logic       cache_commit,
   output logic       merge_en,
   output logic       flush_start,
   output logic       direct_start
);
   logic gate_commit;
   logic gate_unc;

   assign gate_commit = ord_gates_commit(ord_level);
   assign gate_unc    = ord_gates_uncached(ord_level);

   always_comb begin
      st_stall     = 1'b0;
      cache_commit = 1'b0;
      merge_en     = 1'b0;
      flush_start  = 1'b0;
      direct_start = 1'b0;
      if (st_valid) begin
         case (mtype_e'(st_mtype))
            MT_COMBINE: begin
               if (bus_busy) begin
                  st_stall = 1'b1;
               end else if (!buf_any || win_hit) begin
                  merge_en = 1'b1;
               end else begin
                  st_stall    = 1'b1;
                  flush_start = 1'b1;
               end
            end
            MT_CACHED: begin
               if (!ext_empty) begin
                  st_stall = 1'b1;
               end else if (gate_commit && buf_any) begin
                  st_stall    = 1'b1;
                  flush_start = !bus_busy;
               end else begin
                  cache_commit = 1'b1;
               end
            end
            default: begin
               if (bus_busy) begin
                  st_stall = 1'b1;
               end else if (gate_unc && buf_any) begin
                  st_stall    = 1'b1;
                  flush_start = 1'b1;
               end else begin
                  direct_start = 1'b1;
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/wmb_bus_port.sv
module wmb_bus_port #(
   parameter int ADDR_W = 32,
   parameter int LANES  = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 flush_start,
   input  logic                 direct_start,
   input  logic [ADDR_W-1:0]    win_base,
   input  logic [LANES-1:0]     win_be,
   input  logic [LANES*8-1:0]   win_data,
   input  logic [ADDR_W-1:0]    st_addr,
   input  logic [LANES-1:0]     st_be,
   input  logic [LANES*8-1:0]   st_data,
   input  logic                 bus_ack,
   output logic                 bus_req,
   output logic                 from_win,
   output logic                 flush_done,
   output logic [ADDR_W-1:0]    bus_addr,
   output logic [LANES-1:0]     bus_be,
   output logic [LANES*8-1:0]   bus_data
);
   logic                req_q;
   logic                src_q;
   logic [ADDR_W-1:0]   d_addr_q;
   logic [LANES-1:0]    d_be_q;
   logic [LANES*8-1:0]  d_data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         src_q <= 1'b0;
      end else begin
         if (req_q && bus_ack)
            req_q <= 1'b0;
         if (flush_start) begin
            req_q <= 1'b1;
            src_q <= 1'b1;
         end else if (direct_start) begin
            req_q <= 1'b1;
            src_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         d_addr_q <= '0;
         d_be_q   <= '0;
         d_data_q <= '0;
      end else if (direct_start) begin
         d_addr_q <= st_addr;
         d_be_q   <= st_be;
         d_data_q <= st_data;
      end
   end

   assign bus_req    = req_q;
   assign from_win   = src_q;
   assign flush_done = req_q && bus_ack && src_q;
   assign bus_addr   = src_q ? win_base : d_addr_q;
   assign bus_be     = src_q ? win_be   : d_be_q;
   assign bus_data   = src_q ? win_data : d_data_q;

endmodule

// File: rtl/wmb_top.sv
module wmb_top #(
   parameter int ADDR_W = 32,
   parameter int LANES  = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 st_valid,
   input  logic [1:0]           st_mtype,
   input  logic [ADDR_W-1:0]    st_addr,
   input  logic [LANES-1:0]     st_be,
   input  logic [LANES*8-1:0]   st_data,
   input  logic [1:0]           ord_level,
   input  logic                 ext_empty,
   output logic                 st_stall,
   output logic                 cache_commit,
   output logic                 bus_req,
   output logic [ADDR_W-1:0]    bus_addr,
   output logic [LANES-1:0]     bus_be,
   output logic [LANES*8-1:0]   bus_data,
   input  logic                 bus_ack
);
   localparam int OFF_W = $clog2(LANES);

   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("wmb_top: LANES must be a power of two of at least 2");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("wmb_top: ADDR_W must exceed the window offset width");
   end

   logic                merge_en;
   logic                flush_start;
   logic                direct_start;
   logic                flush_done;
   logic                buf_any;
   logic                win_hit;
   logic                bus_from_win;
   logic [ADDR_W-1:0]   win_base;
   logic [LANES-1:0]    win_be;
   logic [LANES*8-1:0]  win_data;

   wmb_merge_buf #(.ADDR_W(ADDR_W), .LANES(LANES)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (merge_en),
      .wr_tag    (st_addr[ADDR_W-1:OFF_W]),
      .wr_be     (st_be),
      .wr_data   (st_data),
      .clr       (flush_done),
      .win_base  (win_base),
      .acc_be    (win_be),
      .acc_data  (win_data),
      .any_valid (buf_any),
      .win_hit   (win_hit)
   );

   wmb_order_ctl u_ctl (
      .st_valid     (st_valid),
      .st_mtype     (st_mtype),
      .ord_level    (ord_level),
      .ext_empty    (ext_empty),
      .buf_any      (buf_any),
      .win_hit      (win_hit),
      .bus_busy     (bus_req),
      .st_stall     (st_stall),
      .cache_commit (cache_commit),
      .merge_en     (merge_en),
      .flush_start  (flush_start),
      .direct_start (direct_start)
   );

   wmb_bus_port #(.ADDR_W(ADDR_W), .LANES(LANES)) u_bus (
      .clk          (clk),
      .rst_n        (rst_n),
      .flush_start  (flush_start),
      .direct_start (direct_start),
      .win_base     (win_base),
      .win_be       (win_be),
      .win_data     (win_data),
      .st_addr      (st_addr),
      .st_be        (st_be),
      .st_data      (st_data),
      .bus_ack      (bus_ack),
      .bus_req      (bus_req),
      .from_win     (bus_from_win),
      .flush_done   (flush_done),
      .bus_addr     (bus_addr),
      .bus_be       (bus_be),
      .bus_data     (bus_data)
   );

endmodule

// File: rtl/wmb_checker.sv
module wmb_checker #(
   parameter int ADDR_W = 32,
   parameter int LANES  = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                st_valid,
   input logic [1:0]          st_mtype,
   input logic [1:0]          ord_level,
   input logic                ext_empty,
   input logic                st_stall,
   input logic                cache_commit,
   input logic                bus_req,
   input logic                bus_ack,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [LANES-1:0]    bus_be,
   input logic [LANES*8-1:0]  bus_data,
   input logic                buf_any,
   input logic                bus_from_win
);
   localparam int OFF_W = $clog2(LANES);

   // R4
   bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_be) && $stable(bus_data));

   // R4
   flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_ack && bus_from_win |=> !buf_any);

   // R5
   commit_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cache_commit |-> ext_empty && !st_stall);

   // R7
   commit_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cache_commit && ord_level != 2'b00 |-> !buf_any);

   // R2
   flush_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_from_win |-> bus_addr[OFF_W-1:0] == '0 && bus_be != '0);

   // R11
   merge_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid && st_mtype == 2'b01 && bus_req |-> st_stall);

   // R1
   stall_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !st_valid |-> !st_stall && !cache_commit);

endmodule

bind wmb_top wmb_checker #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .st_valid     (st_valid),
   .st_mtype     (st_mtype),
   .ord_level    (ord_level),
   .ext_empty    (ext_empty),
   .st_stall     (st_stall),
   .cache_commit (cache_commit),
   .bus_req      (bus_req),
   .bus_ack      (bus_ack),
   .bus_addr     (bus_addr),
   .bus_be       (bus_be),
   .bus_data     (bus_data),
   .buf_any      (buf_any),
   .bus_from_win (bus_from_win)
);

// File: tb/wmb_top_tb.sv
module wmb_top_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int ACK_LAT    = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        st_valid = 1'b0;
   logic [1:0]  st_mtype = 2'b00;
   logic [31:0] st_addr = '0;
   logic [7:0]  st_be = '0;
   logic [63:0] st_data = '0;
   logic [1:0]  ord_level = 2'b00;
   logic        ext_empty = 1'b1;
   logic        st_stall;
   logic        cache_commit;
   logic        bus_req;
   logic [31:0] bus_addr;
   logic [7:0]  bus_be;
   logic [63:0] bus_data;
   logic        bus_ack = 1'b0;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [31:0] log_addr [0:127];
   logic [7:0]  log_be   [0:127];
   logic [63:0] log_data [0:127];
   int n_wr = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wmb_top #(.ADDR_W(32), .LANES(8)) dut_i (
      .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_mtype(st_mtype),
      .st_addr(st_addr), .st_be(st_be), .st_data(st_data), .ord_level(ord_level),
      .ext_empty(ext_empty), .st_stall(st_stall), .cache_commit(cache_commit),
      .bus_req(bus_req), .bus_addr(bus_addr), .bus_be(bus_be), .bus_data(bus_data),
      .bus_ack(bus_ack)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] lane_mask(input logic [7:0] be);
      logic [63:0] m = '0;
      for (int i = 0; i < 8; i++) if (be[i]) m[i*8 +: 8] = 8'hFF;
      return m;
   endfunction

   // Bus responder: acknowledges after ACK_LAT cycles and logs each write
   initial begin
      int wait_cnt = 0;
      logic [31:0] a0; logic [7:0] b0; logic [63:0] d0;
      forever begin
         @(negedge clk);
         bus_ack = 1'b0;
         #2;
         if (bus_req) begin
            wait_cnt++;
            if (wait_cnt == 1) begin
               a0 = bus_addr; b0 = bus_be; d0 = bus_data;
            end else begin
               // R4 payload held while waiting
               chk(bus_addr == a0 && bus_be == b0 && bus_data == d0, "R4 hold", {32'h0, bus_addr}, {32'h0, a0});
            end
            if (wait_cnt == ACK_LAT) begin
               bus_ack = 1'b1;
               if (n_wr < 128) begin
                  log_addr[n_wr] = bus_addr; log_be[n_wr] = bus_be; log_data[n_wr] = bus_data;
               end
               n_wr++;
            end
         end else begin
            wait_cnt = 0;
         end
      end
   end

   task automatic store(input logic [1:0] mt, input logic [31:0] a, input logic [7:0] be,
                        input logic [63:0] d, output int stalls, output bit committed);
      @(negedge clk);
      st_valid = 1'b1; st_mtype = mt; st_addr = a; st_be = be; st_data = d;
      stalls = 0; committed = 0;
      forever begin
         #1;
         if (!st_stall) begin
            committed = cache_commit;
            break;
         end
         stalls++;
         if (stalls > 50) break;
         @(negedge clk);
      end
      @(posedge clk);
      #1 st_valid = 1'b0;
   endtask

   task automatic wait_writes(input int n);
      for (int i = 0; i < 40 && n_wr < n; i++) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int s; bit c; int w0; int eff;
      logic [7:0] ebe; logic [63:0] edat; logic [7:0] be_k; logic [63:0] d_k;
      logic [31:0] base;

      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk(bus_req == 1'b0, "R1 bus_req", {63'h0, bus_req}, 64'h0);
      chk(st_stall == 1'b0 && cache_commit == 1'b0, "R1 stall/commit", {62'h0, st_stall, cache_commit}, 64'h0);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      chk(bus_req == 1'b0, "R1 after release", {63'h0, bus_req}, 64'h0);

      // R2/R3/R7/R11: merge sweep, each closed by a forced flush
      for (int t = 0; t < 16; t++) begin
         base = 32'h1000 + 32'(t) * 8;
         ebe = '0; edat = '0;
         ord_level = (t % 2 == 0) ? 2'b00 : 2'b01;
         for (int k = 0; k < 3; k++) begin
            be_k = 8'((t * 29 + k * 83 + 5) & 255) | ((k == 0) ? 8'h01 : 8'h00);
            d_k  = 64'(t + 1) * 64'h0101010101010101 + 64'(k) * 64'h1030507090B0D0F1;
            store(2'b01, base + 32'(k), be_k, d_k, s, c);
            chk(s == 0, "R2 merge no stall", 64'(s), 64'h0);
            ebe |= be_k;
            edat = (edat & ~lane_mask(be_k)) | (d_k & lane_mask(be_k));
         end
         w0 = n_wr;
         if (t % 2 == 0) begin
            store(2'b01, 32'h9000 + 32'(t) * 8, 8'h00, 64'h0, s, c);
            chk(s == ACK_LAT + 1, "R3/R11 out-of-window stall", 64'(s), 64'(ACK_LAT + 1));
         end else begin
            store(2'b10, 32'h5000, 8'hFF, 64'h0, s, c);
            chk(s == ACK_LAT + 1 && c, "R7 level1 commit after flush", 64'(s), 64'(ACK_LAT + 1));
         end
         chk(n_wr == w0 + 1, "R2 single flush write", 64'(n_wr), 64'(w0 + 1));
         chk(log_addr[w0] == base && log_be[w0] == ebe, "R2 flush addr/be",
             {log_addr[w0], 24'h0, log_be[w0]}, {base, 24'h0, ebe});
         chk((log_data[w0] & lane_mask(ebe)) == edat, "R2 flush data", log_data[w0] & lane_mask(ebe), edat);
      end

      // R5: external buffer not empty holds back a cache commit
      ord_level = 2'b00;
      @(negedge clk);
      ext_empty = 1'b0; st_valid = 1'b1; st_mtype = 2'b10; st_addr = 32'h6000; st_be = 8'hFF;
      for (int i = 0; i < 3; i++) begin
         #1;
         chk(st_stall && !cache_commit, "R5 held by pin", {62'h0, st_stall, cache_commit}, 64'h2);
         @(negedge clk);
      end
      ext_empty = 1'b1;
      #1;
      chk(!st_stall && cache_commit, "R5 released", {62'h0, st_stall, cache_commit}, 64'h1);
      @(posedge clk);
      #1 st_valid = 1'b0;

      // R6/R7/R8/R9/R10: level x class matrix with a held window
      for (int lv = 0; lv < 4; lv++) begin
         for (int m = 0; m < 2; m++) begin
            eff = (lv == 3) ? 2 : lv;
            ord_level = 2'(lv);
            w0 = n_wr;
            store(2'b01, 32'h2000, 8'h0F, 64'h1122334455667788, s, c);
            chk(s == 0, "R2 preload", 64'(s), 64'h0);
            if (m == 0) begin
               store(2'b10, 32'h3000, 8'hF0, 64'hAABBCCDDEEFF0011, s, c);
               if (eff == 0) begin
                  repeat (4) @(negedge clk);
                  chk(s == 0 && c && n_wr == w0, "R6 level0 commit, window kept", 64'(s), 64'h0);
               end else begin
                  chk(s == ACK_LAT + 1 && c, "R7/R10 commit after flush", 64'(s), 64'(ACK_LAT + 1));
                  chk(n_wr == w0 + 1 && log_addr[w0] == 32'h2000, "R7/R10 flushed window",
                      {32'h0, log_addr[w0]}, 64'h2000);
               end
            end else begin
               store(2'b00, 32'h3000, 8'hF0, 64'hAABBCCDDEEFF0011, s, c);
               wait_writes(w0 + ((eff == 2) ? 2 : 1));
               if (eff == 2) begin
                  chk(s == ACK_LAT + 1, "R8/R10 uncached waits for flush", 64'(s), 64'(ACK_LAT + 1));
                  chk(log_addr[w0] == 32'h2000 && log_addr[w0 + 1] == 32'h3000, "R8/R10 write order",
                      {log_addr[w0], log_addr[w0 + 1]}, {32'h2000, 32'h3000});
               end else begin
                  chk(s == 0 && log_addr[w0] == 32'h3000 && log_be[w0] == 8'hF0, "R9 direct write",
                      {log_addr[w0], 24'h0, log_be[w0]}, {32'h3000, 24'h0, 8'hF0});
                  chk((log_data[w0] & lane_mask(8'hF0)) == 64'hAABBCCDD00000000, "R9 direct data",
                      log_data[w0] & lane_mask(8'hF0), 64'hAABBCCDD00000000);
               end
            end
            if ((m == 0 && eff == 0) || (m == 1 && eff < 2)) begin
               ord_level = 2'b01;
               w0 = n_wr;
               store(2'b10, 32'h4000, 8'h00, 64'h0, s, c);
               chk(n_wr == w0 + 1 && log_addr[w0] == 32'h2000 && log_be[w0] == 8'h0F,
                   "R9 window intact", {log_addr[w0], 24'h0, log_be[w0]}, {32'h2000, 24'h0, 8'h0F});
               chk((log_data[w0] & 64'hFFFFFFFF) == 64'h55667788, "R9 window data",
                   log_data[w0] & 64'hFFFFFFFF, 64'h55667788);
            end
         end
      end

      repeat (4) @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule